// File: doc/BRIEF.md
# General-Purpose I/O Register Bank

A bank of up to 32 general-purpose pins controlled through a small word-addressed register bus. Software reads the pin levels, picks a direction for each pin and selects one of four functions per pin. The per-pin output-data, output-enable and function-select signals go out to the pad ring and to the peripheral multiplexers. The bank samples the pin inputs through a two-stage synchronizer.

Output levels never change through a read-modify-write. A write to the set register raises the pins whose data bits are 1. A write to the clear register lowers them. Other pins keep their value. The output latch works independently of the direction. Software can therefore preload a level before turning a pin into an output, and the pad sees no glitch. The pin count is a parameter. Bits of pins that are not built read as zero and ignore writes.

The bus has no wait states. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational on `bus_addr` while `bus_sel` is high and `bus_wr` is low, and is zero otherwise.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin is an input, every function select is 0, the output latch is 0, and every register reads 0 while the pin inputs are low.
- R2: A write to offset 0x08 (set) drives `pin_out[n]` high from the next cycle for every pin n whose data bit n is 1. Every other pin keeps its output value.
- R3: A write to offset 0x0C (clear) drives `pin_out[n]` low from the next cycle for every pin n whose data bit n is 1. Every other pin keeps its output value.
- R4: A write to offset 0x04 (direction) loads bit n into `pin_oe[n]` from the next cycle, where 1 means output and 0 means input. Reading offset 0x04 returns the stored direction bits.
- R5: Offset 0x10 holds the 2-bit function selects of pins 0 to 15, with pin k at bits [2k+1:2k]. Offset 0x14 holds those of pins 16 to 31, with pin 16+k at bits [2k+1:2k]. A write updates `pin_func[2n+1:2n]` from the next cycle, and a read returns the stored fields.
- R6: Reading offset 0x00 (level) returns in bit n the level that `pin_in[n]` had two clock edges earlier, whatever the pin's direction.
- R7: With PIN_COUNT below 32, the bits of the pins that are not built read as zero in every register, and writes to them have no effect.
- R8: The set and clear offsets read as zero. Offsets 0x18 and 0x1C, and addresses that are not a multiple of 4, read as zero, and writes to them change no state.
- R9: A write to any offset other than set or clear leaves `pin_out` unchanged. In particular, changing the direction of a preloaded pin does not alter its output level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pin_in | input | PIN_COUNT | Raw pin levels from the pads |
| pin_out | output | PIN_COUNT | Output latch to the pad drivers |
| pin_oe | output | PIN_COUNT | Output enable, 1 = drive |
| pin_func | output | 2*PIN_COUNT | Function select, two bits per pin |

## Verification
A pin input can toggle in the same cycle that software writes the set, clear or direction register. That change then travels through the synchronizer while later bus cycles read the level register. The bench provokes this with a random phase that changes `pin_in` on every cycle of a mixed stream of writes and reads. A behavioural model delays the input by two edges and updates the latch, direction and function state on its own. Every clock the model's prediction is compared with `bus_rdata`, `pin_out`, `pin_oe` and `pin_func`. Directed checks of the preload-then-turn-on order, the write masking of the pins that are not built, and the unmapped offsets complete the run.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int WORD_W       = 32;
   localparam int REG_AW       = 5;
   localparam int MAX_PINS     = 32;
   localparam int FN_W         = 2;
   localparam int PINS_PER_FN  = WORD_W / FN_W;

   typedef enum logic [REG_AW-1:0] {
      OFS_LEVEL = 5'h00,
      OFS_DIR   = 5'h04,
      OFS_SET   = 5'h08,
      OFS_CLR   = 5'h0C,
      OFS_FNLO  = 5'h10,
      OFS_FNHI  = 5'h14
   } reg_ofs_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync
   import gpio_bank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] level_o
);
   logic [W-1:0] meta_q;
   logic [W-1:0] stab_q;
   logic [1:0]   warm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
      end else begin
         meta_q <= din;
         stab_q <= meta_q;
      end
   end

   assign level_o = stab_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                warm_q <= '0;
      else if (warm_q != 2'd3)   warm_q <= warm_q + 2'd1;
   end

   // R6
   level_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3) |-> (level_o == $past(din, 2)));
endmodule

// File: rtl/gpio_bank_outs.sv
module gpio_bank_outs #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic         dir_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_q
);
   for (genvar p = 0; p < W; p++) begin : g_pin
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q[p] <= 1'b0;
         end else if (set_we && wdata[p]) begin
            out_q[p] <= 1'b1;
         end else if (clr_we && wdata[p]) begin
            out_q[p] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= wdata;
   end

   // R2
   set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((out_q & $past(wdata)) == $past(wdata)));
   // R2
   set_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
   // R3
   clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((out_q & $past(wdata)) == '0));
   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we || clr_we) |=> $stable(out_q));
   // R4
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/gpio_bank_fsel.sv
module gpio_bank_fsel
   import gpio_bank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [WORD_W-1:0] wdata,
   output logic [FN_W*W-1:0] fsel,
   output logic [WORD_W-1:0] lo_rd,
   output logic [WORD_W-1:0] hi_rd
);
   for (genvar p = 0; p < W; p++) begin : g_pin
      localparam int  SLOT  = p % PINS_PER_FN;
      localparam bit  UPPER = (p >= PINS_PER_FN);
      logic            we;
      logic [FN_W-1:0] fs_q;

      assign we = UPPER ? hi_we : lo_we;

      always_ff @(posedge clk) begin
         if (!rst_n)  fs_q <= '0;
         else if (we) fs_q <= wdata[FN_W*SLOT +: FN_W];
      end

      assign fsel[FN_W*p +: FN_W] = fs_q;
   end

   always_comb begin
      lo_rd = '0;
      hi_rd = '0;
      for (int p = 0; p < W; p++) begin
         if (p >= PINS_PER_FN) hi_rd[FN_W*(p % PINS_PER_FN) +: FN_W] = fsel[FN_W*p +: FN_W];
         else                  lo_rd[FN_W*(p % PINS_PER_FN) +: FN_W] = fsel[FN_W*p +: FN_W];
      end
   end

   // R5
   fsel_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> (fsel[FN_W-1:0] == $past(wdata[FN_W-1:0])));
   // R5
   fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lo_we || hi_we) |=> $stable(fsel));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int PIN_COUNT = 21
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_sel,
   input  logic                      bus_wr,
   input  logic [REG_AW-1:0]         bus_addr,
   input  logic [WORD_W-1:0]         bus_wdata,
   output logic [WORD_W-1:0]         bus_rdata,
   input  logic [PIN_COUNT-1:0]      pin_in,
   output logic [PIN_COUNT-1:0]      pin_out,
   output logic [PIN_COUNT-1:0]      pin_oe,
   output logic [FN_W*PIN_COUNT-1:0] pin_func
);
   if (PIN_COUNT < 1 || PIN_COUNT > MAX_PINS) begin : g_bad_count
      $error("gpio_bank_regs: PIN_COUNT must be 1..32");
   end

   logic wr_acc, rd_acc;
   logic we_set, we_clr, we_dir, we_flo, we_fhi;
   logic [PIN_COUNT-1:0] level;
   logic [WORD_W-1:0]    fn_lo_rd, fn_hi_rd;

   assign wr_acc = bus_sel &&  bus_wr;
   assign rd_acc = bus_sel && !bus_wr;
   assign we_set = wr_acc && (bus_addr == OFS_SET);
   assign we_clr = wr_acc && (bus_addr == OFS_CLR);
   assign we_dir = wr_acc && (bus_addr == OFS_DIR);
   assign we_flo = wr_acc && (bus_addr == OFS_FNLO);
   assign we_fhi = wr_acc && (bus_addr == OFS_FNHI);

   gpio_bank_sync #(.W(PIN_COUNT)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (pin_in),
      .level_o (level)
   );

   gpio_bank_outs #(.W(PIN_COUNT)) i_outs (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (we_set),
      .clr_we (we_clr),
      .dir_we (we_dir),
      .wdata  (bus_wdata[PIN_COUNT-1:0]),
      .out_q  (pin_out),
      .dir_q  (pin_oe)
   );

   gpio_bank_fsel #(.W(PIN_COUNT)) i_fsel (
      .clk   (clk),
      .rst_n (rst_n),
      .lo_we (we_flo),
      .hi_we (we_fhi),
      .wdata (bus_wdata),
      .fsel  (pin_func),
      .lo_rd (fn_lo_rd),
      .hi_rd (fn_hi_rd)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         unique case (bus_addr)
            OFS_LEVEL: bus_rdata = WORD_W'(level);
            OFS_DIR:   bus_rdata = WORD_W'(pin_oe);
            OFS_FNLO:  bus_rdata = fn_lo_rd;
            OFS_FNHI:  bus_rdata = fn_hi_rd;
            default:   bus_rdata = '0;
         endcase
      end
   end

   // R8
   strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |-> (bus_rdata == '0));
   // R4
   dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && bus_addr == OFS_DIR) |-> (bus_rdata[PIN_COUNT-1:0] == pin_oe));
endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
   localparam int N = 21;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_sel, bus_wr;
   logic [4:0]        bus_addr;
   logic [31:0]       bus_wdata;
   logic [31:0]       bus_rdata;
   logic [N-1:0]      pin_in;
   logic [N-1:0]      pin_out, pin_oe;
   logic [2*N-1:0]    pin_func;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   gpio_bank_regs #(.PIN_COUNT(N)) i_gpio_bank_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func)
   );

   // ---------------- reference model ----------------
   logic [31:0] pmask, flmask, fhmask;
   logic [31:0] m_out, m_dir, m_s1, m_s2, m_flo, m_fhi;

   initial begin
      pmask = 0; flmask = 0; fhmask = 0;
      for (int k = 0; k < N; k++) begin
         pmask[k] = 1'b1;
         if (k < 16) begin flmask[2*k] = 1'b1; flmask[2*k+1] = 1'b1; end
         else begin fhmask[2*(k-16)] = 1'b1; fhmask[2*(k-16)+1] = 1'b1; end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_out <= 0; m_dir <= 0; m_s1 <= 0; m_s2 <= 0; m_flo <= 0; m_fhi <= 0;
      end else begin
         m_s1 <= 32'(pin_in);
         m_s2 <= m_s1;
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               5'h04: m_dir <= bus_wdata & pmask;
               5'h08: m_out <= m_out | (bus_wdata & pmask);
               5'h0C: m_out <= m_out & ~(bus_wdata & pmask);
               5'h10: m_flo <= bus_wdata & flmask;
               5'h14: m_fhi <= bus_wdata & fhmask;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] model_read();
      if (!(bus_sel && !bus_wr)) return 0;
      case (bus_addr)
         5'h00:   return m_s2;
         5'h04:   return m_dir;
         5'h10:   return m_flo;
         5'h14:   return m_fhi;
         default: return 0;
      endcase
   endfunction

   function automatic string addr_tag();
      case (bus_addr)
         5'h00:        return "R6";
         5'h04:        return "R4";
         5'h10, 5'h14: return "R5";
         default:      return "R8";
      endcase
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, after the edge has settled
   always begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
         chk(addr_tag(), 64'(bus_rdata), 64'(model_read()));
         chk("R2/R3 pin_out", 64'(pin_out), 64'(m_out[N-1:0]));
         chk("R4 pin_oe", 64'(pin_oe), 64'(m_dir[N-1:0]));
         chk("R5 pin_func", 64'(pin_func), 64'({m_fhi, m_flo} & ((64'd1 << (2*N)) - 1)));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      idle();
   endtask

   task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = 0;
      #1;
      chk(req, 64'(bus_rdata), 64'(exp));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      idle();
      // R1 reset state
      chk("R1 pin_out", 64'(pin_out), 0);
      chk("R1 pin_oe", 64'(pin_oe), 0);
      chk("R1 pin_func", 64'(pin_func), 0);
      rd_chk("R1 level", 5'h00, 0);
      rd_chk("R1 dir", 5'h04, 0);
      rd_chk("R1 fnlo", 5'h10, 0);
      rd_chk("R1 fnhi", 5'h14, 0);
      idle();
      // R2 / R3
      wr(5'h08, 32'h0000_00A5);
      chk("R2 set", 64'(pin_out), 64'h0A5);
      wr(5'h08, 32'h0000_0100);
      chk("R2 set keeps others", 64'(pin_out), 64'h1A5);
      wr(5'h0C, 32'h0000_0005);
      chk("R3 clear", 64'(pin_out), 64'h1A0);
      // R9 preload then turn on
      wr(5'h08, 32'h0000_0008);
      wr(5'h04, 32'h0000_0008);
      chk("R9 preload kept", 64'(pin_out), 64'h1A8);
      chk("R4 oe", 64'(pin_oe), 64'h008);
      // R7 pins that are not built
      wr(5'h04, 32'hFFFF_FFFF);
      rd_chk("R7 dir mask", 5'h04, 32'h001F_FFFF);
      wr(5'h08, 32'hFFFF_FFFF);
      chk("R7 set mask", 64'(pin_out), 64'h1F_FFFF);
      // R8 strobes and unmapped offsets
      rd_chk("R8 set reads 0", 5'h08, 0);
      rd_chk("R8 clear reads 0", 5'h0C, 0);
      wr(5'h18, 32'h0000_0000);
      wr(5'h0E, 32'hFFFF_FFFF);
      wr(5'h1C, 32'hFFFF_FFFF);
      chk("R8 unmapped write", 64'(pin_out), 64'h1F_FFFF);
      rd_chk("R8 unmapped read", 5'h18, 0);
      rd_chk("R8 dir intact", 5'h04, 32'h001F_FFFF);
      // R5 function selects
      wr(5'h10, 32'hE4E4_E4E4);
      rd_chk("R5 fnlo", 5'h10, 32'hE4E4_E4E4);
      wr(5'h14, 32'hFFFF_FFFF);
      rd_chk("R7 fnhi mask", 5'h14, 32'h0000_03FF);
      chk("R5 pin_func", 64'(pin_func), {22'h0, 10'h3FF, 32'hE4E4_E4E4});
      // R6 level through the synchronizer, regardless of direction
      idle();
      pin_in = 21'h15_5A5A;
      repeat (2) idle();
      rd_chk("R6 level", 5'h00, 32'h0015_5A5A);
      wr(5'h04, 32'h0);
      pin_in = 21'h0A_A5A5;
      repeat (2) idle();
      rd_chk("R6 level input", 5'h00, 32'h000A_A5A5);
      idle();
      // random mixed traffic with toggling inputs, checked by the model
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         pin_in    = N'($urandom);
         bus_sel   = ($urandom % 4) != 0;
         bus_wr    = $urandom % 2;
         case ($urandom % 8)
            0: bus_addr = 5'h00;
            1: bus_addr = 5'h04;
            2: bus_addr = 5'h08;
            3: bus_addr = 5'h0C;
            4: bus_addr = 5'h10;
            5: bus_addr = 5'h14;
            6: bus_addr = 5'h18;
            default: bus_addr = 5'h02;
         endcase
         bus_wdata = $urandom;
      end
      idle();
      idle();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule